// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a countdown timer clocked by the bus clock through a power-of-two prescaler. Software loads an initial count, picks a division ratio with a four-bit code, and programs the timer's local-vector entry: a vector number, a mask bit and a periodic/one-shot bit. Each time the count runs out, the block adds one tick to a pending-tick counter. While the unit is enabled and the timer entry is unmasked, the block asks downstream logic to take a tick. A tick that downstream accepts is removed from the counter.

The block also holds the mask bits of the other local-vector entries. It forces all of them to masked while the software-enable input is low. The current count can be read at any time. It gives the whole prescaler intervals left in the running period and restarts from the initial count after each periodic expiry.

Top module: `pit_timer`

## Requirements
- R1: The divisor equals 2 raised to ((the 3-bit value {cfg[3], cfg[1], cfg[0]} + 1) mod 8). So code 4'b0000 divides by 2, 4'b0001 by 4, 4'b0011 by 16, 4'b1000 by 32, 4'b1001 by 64, 4'b1010 by 128, and both 4'b1011 and 4'b1111 by 1. The first expiry after a start comes exactly initial count × divisor clock edges after the edge that took the initial-count write.
- R2: Bit 2 of the divide code has no effect on the divisor. `divCfgErr` shows bit 2 of the most recently written code.
- R3: Writing a nonzero initial count N restarts the timer. `curCount` reads N after the writing edge and drops by one every divisor edges.
- R4: Writing an initial count of zero stops the timer. `curCount` then reads 0 and no expiry occurs.
- R5: If the timer entry's periodic bit is 1, the count reloads to N at expiry and keeps running. If it is 0, the count goes to 0 at expiry and stops.
- R6: Each expiry adds one to `pendCount` on the expiry edge.
- R7: `pendCount` saturates at 2^PEND_W−1 and does not wrap. An expiry and an accepted delivery on the same edge leave it unchanged.
- R8: `deliverReq` is high exactly when `swEnable` is 1, the timer entry's mask is 0 and `pendCount` is nonzero. `deliverAck` while `deliverReq` is high removes one tick. `deliverAck` while `deliverReq` is low changes nothing.
- R9: Any initial-count write clears `pendCount` to 0.
- R10: While `swEnable` is 0, every bit of `lvtMaskOut` is forced to 1 and `pendCount` is held at 0. A local-vector write made during that time cannot clear a mask bit.
- R11: After reset, `lvtMaskOut` is all ones, `pendCount`, `curCount`, `timerVector` and `divCfgErr` are 0, the divide code is 0 and the timer entry is one-shot.
- R12: A local-vector write with select 0 sets the timer entry's vector, mask and periodic bit. A select of 1 to NUM_LVT−1 sets only that entry's mask bit (bit i of `lvtMaskOut`). A select of NUM_LVT or above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| swEnable | input | 1 | Software enable of the unit |
| divWrEn | input | 1 | Write strobe for the divide code |
| divWrData | input | 4 | Divide code |
| icntWrEn | input | 1 | Write strobe for the initial count |
| icntWrData | input | CNT_W | Initial count |
| lvtWrEn | input | 1 | Write strobe for a local-vector entry |
| lvtWrSel | input | SEL_W | Entry select, 0 is the timer entry |
| lvtWrVector | input | VEC_W | Vector number for the timer entry |
| lvtWrMask | input | 1 | Mask bit for the selected entry |
| lvtWrPeriodic | input | 1 | Periodic bit for the timer entry |
| deliverAck | input | 1 | Downstream accepts the offered tick |
| curCount | output | CNT_W | Current count readback |
| pendCount | output | PEND_W | Pending tick counter |
| deliverReq | output | 1 | A tick is offered for delivery |
| timerVector | output | VEC_W | Vector of the timer entry |
| lvtMaskOut | output | NUM_LVT | Mask bits of all entries |
| divCfgErr | output | 1 | Bit 2 of the stored divide code |

## Verification
All register writes take effect on the edge that samples them. The count, the masks and the pending counter show new values one edge later. `deliverReq` is combinational on that state. The first expiry after an initial-count write lands N × divisor edges after the write edge, so the bench measures that distance for each divide code and compares it with the computed product. Stimulus is driven and results are sampled on the falling clock edge, so each check looks at the state left by exactly the rising edges counted before it.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int SHIFT_W = 3;
  localparam int PRE_W   = (1 << SHIFT_W) - 1;

  typedef struct packed {
    logic               restart;
    logic               periodic;
    logic [SHIFT_W-1:0] divShift;
  } pitStrobe_t;

  // Divide code to shift amount; bit 2 of the code is skipped.
  function automatic logic [SHIFT_W-1:0] divCodeToShift(input logic [3:0] code);
    logic [3:0] t;
    t = {1'b0, code[3], code[1:0]} + 4'd1;
    return t[SHIFT_W-1:0];
  endfunction

endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pitStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] curCount,
  output logic             expire
);

  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [PRE_W:0]   divFull;
  logic [PRE_W-1:0] preLoad;
  logic             running;

  assign divFull = (PRE_W+1)'(1) << strobe.divShift;
  assign preLoad = PRE_W'(divFull - (PRE_W+1)'(1));
  assign running = (cnt != '0);
  assign expire  = running && (pre == '0) && (cnt == CNT_W'(1)) && !strobe.restart;
  assign curCount = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
      cnt       <= '0;
      pre       <= '0;
    end else if (strobe.restart) begin
      reloadVal <= loadVal;
      cnt       <= loadVal;
      pre       <= preLoad;
    end else if (running) begin
      if (pre == '0) begin
        pre <= preLoad;
        if (cnt == CNT_W'(1)) begin
          cnt <= strobe.periodic ? reloadVal : '0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end else begin
        pre <= pre - PRE_W'(1);
      end
    end
  end

  // R3: a restart shows the loaded value after its edge
  assert_restart_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> curCount == $past(loadVal));

  // R3: a running count holds or steps down by one between expiries
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && curCount != '0 && !expire) |=>
      (curCount == $past(curCount) || curCount == $past(curCount) - CNT_W'(1)));

  // R5: a one-shot expiry leaves the count at zero
  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !strobe.periodic) |=> curCount == '0);

  // R4: a stopped timer stays stopped until the next load
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && curCount == '0) |=> curCount == '0);

endmodule

// File: rtl/pit_control.sv
module pit_control
  import pit_pkg::*;
#(
  parameter int PEND_W  = 4,
  parameter int NUM_LVT = 6,
  parameter int VEC_W   = 8,
  localparam int SEL_W  = (NUM_LVT > 1) ? $clog2(NUM_LVT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swEnable,
  input  logic               divWrEn,
  input  logic [3:0]         divWrData,
  input  logic               icntWrEn,
  input  logic               lvtWrEn,
  input  logic [SEL_W-1:0]   lvtWrSel,
  input  logic [VEC_W-1:0]   lvtWrVector,
  input  logic               lvtWrMask,
  input  logic               lvtWrPeriodic,
  input  logic               deliverAck,
  input  logic               expire,
  output pitStrobe_t         strobe,
  output logic [PEND_W-1:0]  pendCount,
  output logic               deliverReq,
  output logic [VEC_W-1:0]   timerVector,
  output logic [NUM_LVT-1:0] lvtMaskOut,
  output logic               divCfgErr
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [3:0]         divCfg;
  logic               timerPeriodic;
  logic [NUM_LVT-1:0] lvtMask;
  logic               timerSel;
  logic               takeTick;

  assign timerSel = lvtWrEn && (lvtWrSel == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCfg        <= '0;
      timerVector   <= '0;
      timerPeriodic <= 1'b0;
    end else begin
      if (divWrEn) divCfg <= divWrData;
      if (timerSel) begin
        timerVector   <= lvtWrVector;
        timerPeriodic <= lvtWrPeriodic;
      end
    end
  end

  for (genvar i = 0; i < NUM_LVT; i++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lvtMask[i] <= 1'b1;
      end else if (!swEnable) begin
        lvtMask[i] <= 1'b1;
      end else if (lvtWrEn && (lvtWrSel == SEL_W'(i))) begin
        lvtMask[i] <= lvtWrMask;
      end
    end
  end

  assign lvtMaskOut = lvtMask;
  assign divCfgErr  = divCfg[2];

  assign strobe.restart  = icntWrEn;
  assign strobe.periodic = timerPeriodic;
  assign strobe.divShift = divCodeToShift(divCfg);

  assign deliverReq = swEnable && !lvtMask[0] && (pendCount != '0);
  assign takeTick   = deliverReq && deliverAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCount <= '0;
    end else if (!swEnable || icntWrEn) begin
      pendCount <= '0;
    end else if (expire && !takeTick) begin
      if (pendCount != PEND_MAX) pendCount <= pendCount + PEND_W'(1);
    end else if (takeTick && !expire) begin
      pendCount <= pendCount - PEND_W'(1);
    end
  end

  // R7: the pending counter never wraps past its top value
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (swEnable && !icntWrEn && expire && !takeTick && pendCount == PEND_MAX)
      |=> pendCount == PEND_MAX);

  // R6: an expiry with nothing taken adds one tick
  assert_tick_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (swEnable && !icntWrEn && expire && !deliverReq && pendCount != PEND_MAX)
      |=> pendCount == $past(pendCount) + PEND_W'(1));

  // R8: an accepted delivery removes exactly one tick
  assert_take_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    (swEnable && !icntWrEn && deliverReq && deliverAck && !expire)
      |=> pendCount == $past(pendCount) - PEND_W'(1));

  // R9: a new initial count flushes pending ticks
  assert_restart_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    icntWrEn |=> pendCount == '0);

  // R10: disabling masks every entry and empties the counter
  assert_disable_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    !swEnable |=> (lvtMaskOut == '1 && pendCount == '0));

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PEND_W  = 4,
  parameter int NUM_LVT = 6,
  parameter int VEC_W   = 8,
  localparam int SEL_W  = (NUM_LVT > 1) ? $clog2(NUM_LVT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swEnable,
  input  logic               divWrEn,
  input  logic [3:0]         divWrData,
  input  logic               icntWrEn,
  input  logic [CNT_W-1:0]   icntWrData,
  input  logic               lvtWrEn,
  input  logic [SEL_W-1:0]   lvtWrSel,
  input  logic [VEC_W-1:0]   lvtWrVector,
  input  logic               lvtWrMask,
  input  logic               lvtWrPeriodic,
  input  logic               deliverAck,
  output logic [CNT_W-1:0]   curCount,
  output logic [PEND_W-1:0]  pendCount,
  output logic               deliverReq,
  output logic [VEC_W-1:0]   timerVector,
  output logic [NUM_LVT-1:0] lvtMaskOut,
  output logic               divCfgErr
);

  pitStrobe_t strobe;
  logic       expire;

  pit_control #(
    .PEND_W (PEND_W),
    .NUM_LVT(NUM_LVT),
    .VEC_W  (VEC_W)
  ) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .swEnable     (swEnable),
    .divWrEn      (divWrEn),
    .divWrData    (divWrData),
    .icntWrEn     (icntWrEn),
    .lvtWrEn      (lvtWrEn),
    .lvtWrSel     (lvtWrSel),
    .lvtWrVector  (lvtWrVector),
    .lvtWrMask    (lvtWrMask),
    .lvtWrPeriodic(lvtWrPeriodic),
    .deliverAck   (deliverAck),
    .expire       (expire),
    .strobe       (strobe),
    .pendCount    (pendCount),
    .deliverReq   (deliverReq),
    .timerVector  (timerVector),
    .lvtMaskOut   (lvtMaskOut),
    .divCfgErr    (divCfgErr)
  );

  pit_datapath #(
    .CNT_W(CNT_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadVal (icntWrData),
    .curCount(curCount),
    .expire  (expire)
  );

endmodule

// File: tb/pit_timer_bench.sv
module pit_timer_bench;

  localparam int CNT_W = 16;
  localparam int PEND_W = 4;
  localparam int NUM_LVT = 6;
  localparam int VEC_W = 8;
  localparam int SEL_W = 3;
  localparam int NVEC = 9;

  // {divide code[31:28], initial count[27:16], expected edges to expiry[15:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0003_0006, 32'hB005_0005, 32'h3002_0020, 32'h8001_0020, 32'hA001_0080,
    32'h4003_0006, 32'h9002_0080, 32'h1004_0010, 32'hF002_0002
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swEnable = 1'b0;
  logic divWrEn = 1'b0;
  logic [3:0] divWrData = '0;
  logic icntWrEn = 1'b0;
  logic [CNT_W-1:0] icntWrData = '0;
  logic lvtWrEn = 1'b0;
  logic [SEL_W-1:0] lvtWrSel = '0;
  logic [VEC_W-1:0] lvtWrVector = '0;
  logic lvtWrMask = 1'b0;
  logic lvtWrPeriodic = 1'b0;
  logic deliverAck = 1'b0;
  logic [CNT_W-1:0] curCount;
  logic [PEND_W-1:0] pendCount;
  logic deliverReq;
  logic [VEC_W-1:0] timerVector;
  logic [NUM_LVT-1:0] lvtMaskOut;
  logic divCfgErr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  int k;
  logic [3:0] vDiv;
  logic [11:0] vCnt;
  logic [15:0] vExp;

  always #5 clk = ~clk;

  pit_timer #(.CNT_W(CNT_W), .PEND_W(PEND_W), .NUM_LVT(NUM_LVT), .VEC_W(VEC_W)) u_pit_timer (
    .clk(clk), .rstN(rstN), .swEnable(swEnable), .divWrEn(divWrEn), .divWrData(divWrData),
    .icntWrEn(icntWrEn), .icntWrData(icntWrData), .lvtWrEn(lvtWrEn), .lvtWrSel(lvtWrSel),
    .lvtWrVector(lvtWrVector), .lvtWrMask(lvtWrMask), .lvtWrPeriodic(lvtWrPeriodic),
    .deliverAck(deliverAck), .curCount(curCount), .pendCount(pendCount),
    .deliverReq(deliverReq), .timerVector(timerVector), .lvtMaskOut(lvtMaskOut),
    .divCfgErr(divCfgErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrDiv(input logic [3:0] c);
    divWrEn = 1'b1; divWrData = c;
    @(negedge clk);
    divWrEn = 1'b0;
  endtask

  task automatic wrCnt(input logic [CNT_W-1:0] n);
    icntWrEn = 1'b1; icntWrData = n;
    @(negedge clk);
    icntWrEn = 1'b0;
  endtask

  task automatic wrLvt(input logic [SEL_W-1:0] sel, input logic [VEC_W-1:0] vec,
                       input logic msk, input logic per);
    lvtWrEn = 1'b1; lvtWrSel = sel; lvtWrVector = vec; lvtWrMask = msk; lvtWrPeriodic = per;
    @(negedge clk);
    lvtWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    swEnable = 1'b1;
    tick(1);
    // R11 reset state
    check("R11 masks", 32'(lvtMaskOut), 32'h3F);
    check("R11 pending", 32'(pendCount), 0);
    check("R11 count", 32'(curCount), 0);
    check("R11 vector", 32'(timerVector), 0);
    check("R11 divErr", 32'(divCfgErr), 0);
    check("R11 req", 32'(deliverReq), 0);
    tick(5);
    check("R11 idle count", 32'(curCount), 0);

    // R12 entry writes
    wrLvt(3'd0, 8'h31, 1'b0, 1'b1);
    check("R12 timer vector", 32'(timerVector), 32'h31);
    check("R12 timer mask", 32'(lvtMaskOut), 32'h3E);
    wrLvt(3'd3, 8'h00, 1'b0, 1'b0);
    check("R12 entry3 mask", 32'(lvtMaskOut), 32'h36);
    check("R12 entry3 keeps vector", 32'(timerVector), 32'h31);
    wrLvt(3'd7, 8'h00, 1'b0, 1'b0);
    check("R12 out of range", 32'(lvtMaskOut), 32'h36);
    wrLvt(3'd0, 8'h31, 1'b1, 1'b0);
    check("R12 remask", 32'(lvtMaskOut), 32'h37);

    // R1, R2 divide table, one-shot
    for (int i = 0; i < NVEC; i++) begin
      vDiv = VEC[i][31:28];
      vCnt = VEC[i][27:16];
      vExp = VEC[i][15:0];
      wrDiv(vDiv);
      check("R2 divErr flag", 32'(divCfgErr), 32'(vDiv[2]));
      wrCnt(CNT_W'(vCnt));
      check("R3 loaded count", 32'(curCount), 32'(vCnt));
      k = 0;
      while (pendCount == '0 && k < 1000) begin
        @(negedge clk);
        k++;
      end
      check("R1 edges to expiry", 32'(k), 32'(vExp));
      check("R5 one-shot stop", 32'(curCount), 0);
      check("R6 one tick", 32'(pendCount), 1);
    end

    // R5 periodic reload, divide by 1
    wrDiv(4'b1011);
    wrLvt(3'd0, 8'h31, 1'b1, 1'b1);
    wrCnt(16'd4);
    check("R9 restart flush", 32'(pendCount), 0);
    check("R3 load 4", 32'(curCount), 4);
    tick(3);
    check("R3 step down", 32'(curCount), 1);
    tick(1);
    check("R5 reload", 32'(curCount), 4);
    check("R6 first tick", 32'(pendCount), 1);
    tick(4);
    check("R5 second period", 32'(curCount), 4);
    check("R6 second tick", 32'(pendCount), 2);

    // R4 stop with zero
    wrCnt(16'd0);
    check("R4 stop count", 32'(curCount), 0);
    check("R9 stop flush", 32'(pendCount), 0);
    tick(50);
    check("R4 no expiry", 32'(pendCount), 0);

    // R8 delivery
    wrLvt(3'd0, 8'h31, 1'b0, 1'b0);
    wrCnt(16'd1);
    tick(1);
    check("R8 tick present", 32'(pendCount), 1);
    check("R8 request", 32'(deliverReq), 1);
    deliverAck = 1'b1; tick(1); deliverAck = 1'b0;
    check("R8 taken", 32'(pendCount), 0);
    check("R8 request drops", 32'(deliverReq), 0);
    deliverAck = 1'b1; tick(1); deliverAck = 1'b0;
    check("R8 ack on empty", 32'(pendCount), 0);
    wrCnt(16'd1);
    tick(1);
    wrLvt(3'd0, 8'h31, 1'b1, 1'b0);
    check("R8 masked no request", 32'(deliverReq), 0);
    deliverAck = 1'b1; tick(1); deliverAck = 1'b0;
    check("R8 masked ack ignored", 32'(pendCount), 1);

    // R7 saturation
    wrLvt(3'd0, 8'h31, 1'b1, 1'b1);
    wrCnt(16'd1);
    tick(20);
    check("R7 saturate", 32'(pendCount), 15);
    wrLvt(3'd0, 8'h31, 1'b0, 1'b1);
    deliverAck = 1'b1;
    tick(3);
    check("R7 expiry plus take", 32'(pendCount), 15);
    check("R8 request at top", 32'(deliverReq), 1);
    deliverAck = 1'b0;

    // R9 flush on restart
    wrCnt(16'd200);
    check("R9 flush", 32'(pendCount), 0);

    // R10 software disable
    swEnable = 1'b0;
    tick(1);
    check("R10 all masked", 32'(lvtMaskOut), 32'h3F);
    check("R10 pending clear", 32'(pendCount), 0);
    tick(250);
    check("R10 pending held", 32'(pendCount), 0);
    wrLvt(3'd0, 8'h31, 1'b0, 1'b0);
    check("R10 write masked", 32'(lvtMaskOut), 32'h3F);
    swEnable = 1'b1;
    tick(1);
    check("R10 mask stays", 32'(lvtMaskOut), 32'h3F);

    // R3 rate with divide by 2
    wrDiv(4'b0000);
    wrCnt(16'd3);
    check("R3 load 3", 32'(curCount), 3);
    tick(1);
    check("R3 hold first edge", 32'(curCount), 3);
    tick(1);
    check("R3 step after two", 32'(curCount), 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule